// File: doc/BRIEF.md
# DRAM Fast Page Mode Sequencer

This block sits on the controller side of an asynchronous DRAM. It takes one access request at a time, each carrying a row, a column, a direction and write data. It opens a row by pulling the row strobe low with the row address on the multiplexed address bus. It then serves every following request to that row as a short column-strobe cycle while the row strobe stays low. A request to another row, a cycle with nothing pending, or a row-active budget that could not cover one more column cycle closes the row. The sequencer then waits out the precharge time before it opens a row again.

Requests use a valid/ready handshake. `req_valid` must stay high with a stable payload until the cycle in which `req_ready` is high. `req_ready` is high when the row is closed and precharged. It is also high while a row is open between column cycles, but only if the waiting request hits that row and the budget allows one more access. In that state `req_ready` depends on the request payload. Only one request is in flight, so read data returns in request order with a single-cycle `rd_valid` strobe and no back-pressure. A per-bit write mask is sampled on the clock edge where the row strobe falls, and it governs every write in that page.

Top module: `fpm_seq`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `rd_valid` is low and `req_ready` is high.
- R2: In the first cycle with `dram_ras_n` low, `dram_addr` carries the request row. In the first cycle of each column strobe, `dram_addr` carries the column in its low bits.
- R3: Back-to-back requests to the open row are served as separate column strobes within one row-strobe low period, with no new row opening.
- R4: The first column strobe after a row opens stays low for exactly FIRST_LAT cycles.
- R5: Every later column strobe in the same page stays low for exactly CAS_LAT cycles.
- R6: Between two row-strobe low periods, `dram_ras_n` stays high for at least T_RP cycles.
- R7: `dram_ras_n` is never low for more than RAS_MAX consecutive cycles. A same-row burst longer than the budget is split across several row openings.
- R8: If no request is valid in the cycle after a column strobe ends, `dram_ras_n` is high in the next cycle.
- R9: During a write strobe (`dram_cas_n` and `dram_we_n` low, `dram_oe_n` high), `dram_bwe` equals the value of `wr_mask` at the row-opening edge, even if `wr_mask` has changed since. A 1 bit enables that data bit. Outside write strobes, `dram_bwe` is zero.
- R10: For each read, `rd_valid` pulses for one cycle in the cycle after the strobe ends. `rd_data` holds the value of `dram_dq_in` from the strobe's last cycle, and results come back in request order.
- R11: `req_ready` is low whenever `dram_cas_n` is low or precharge is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write enable, sampled when a row opens |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | DATA_W | Read result |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Write data to the device |
| dram_bwe | output | DATA_W | Per-bit write enable to the device |
| dram_dq_in | input | DATA_W | Read data from the device |

## Verification
Two events can land in the same cycle. A same-row request can arrive exactly when the row-active budget has run out, so a page hit and a forced close compete. The row opening can also coincide with a change of `wr_mask`. The bench provokes the first case with a long same-row read burst under a small RAS_MAX. It judges the result by the length of every row-strobe low period, by the number of row openings, and by every read still returning the right data in order. The second case is provoked by changing the mask right after a page opens and again every cycle in the random phase. A bench memory model applies `dram_bwe` on writes, so a wrong mask appears as a wrong read value.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CAS,
    ST_OPEN,
    ST_PRE
  } fpm_state_t;
endpackage

// File: rtl/fpm_countdown.sv
module fpm_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/fpm_ras_budget.sv
module fpm_ras_budget #(
  parameter int RAS_MAX = 20000,
  parameter int CAS_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic fits
);
  localparam int CW = $clog2(RAS_MAX + 1);
  logic [CW-1:0] cnt;

  // cnt holds the number of earlier cycles of the current low period
  always_ff @(posedge clk) begin
    if (!rst_n || !ras_low) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // this cycle + one more strobe + the following open cycle
  assign fits = (int'(cnt) + CAS_LAT + 2) <= RAS_MAX;
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 8,
  parameter int FIRST_LAT = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 3,
  parameter int RAS_MAX   = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] wr_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic [DATA_W-1:0] dram_bwe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LMAX = (FIRST_LAT > CAS_LAT) ?
                        ((FIRST_LAT > T_RP) ? FIRST_LAT : T_RP) :
                        ((CAS_LAT > T_RP) ? CAS_LAT : T_RP);
  localparam int LW   = $clog2(LMAX + 1);

  fpm_state_t        st, st_nx;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] page_mask;
  logic              hit, fits, accept;
  logic              cas_load, cas_last, pre_load, pre_last;
  logic [LW-1:0]     cas_val;
  logic              ras_low;

  assign hit = (req_row == cur_row);

  always_comb begin
    case (st)
      ST_IDLE: req_ready = 1'b1;
      ST_OPEN: req_ready = req_valid && hit && fits;
      default: req_ready = 1'b0;
    endcase
  end
  assign accept = req_valid && req_ready;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) st_nx = ST_ACT;
      ST_ACT:  st_nx = ST_CAS;
      ST_CAS:  if (cas_last) st_nx = ST_OPEN;
      ST_OPEN: st_nx = accept ? ST_CAS : ST_PRE;
      ST_PRE:  if (pre_last) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign cas_load = (st == ST_ACT) || ((st == ST_OPEN) && accept);
  assign cas_val  = (st == ST_ACT) ? LW'(FIRST_LAT) : LW'(CAS_LAT);
  assign pre_load = (st == ST_OPEN) && !accept;

  fpm_countdown #(.W(LW)) u_cas_cnt (
    .clk(clk), .rst_n(rst_n), .load(cas_load), .val(cas_val), .last(cas_last)
  );

  fpm_countdown #(.W(LW)) u_pre_cnt (
    .clk(clk), .rst_n(rst_n), .load(pre_load), .val(LW'(T_RP)), .last(pre_last)
  );

  assign ras_low = (st == ST_ACT) || (st == ST_CAS) || (st == ST_OPEN);

  fpm_ras_budget #(.RAS_MAX(RAS_MAX), .CAS_LAT(CAS_LAT)) u_budget (
    .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .fits(fits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      cur_data  <= '0;
      page_mask <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      st       <= st_nx;
      rd_valid <= (st == ST_CAS) && cas_last && !cur_wr;
      if ((st == ST_CAS) && cas_last && !cur_wr) rd_data <= dram_dq_in;
      if (accept) begin
        cur_row  <= req_row;
        cur_col  <= req_col;
        cur_wr   <= req_wr;
        cur_data <= req_wdata;
      end
      // mask is taken on the edge where the row strobe falls
      if (accept && (st == ST_IDLE)) page_mask <= wr_mask;
    end
  end

  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = (st != ST_CAS);
  assign dram_we_n   = !((st == ST_CAS) && cur_wr);
  assign dram_oe_n   = !((st == ST_CAS) && !cur_wr);
  assign dram_addr   = (st == ST_CAS) ? AW'(cur_col) : AW'(cur_row);
  assign dram_dq_out = cur_data;
  assign dram_bwe    = ((st == ST_CAS) && cur_wr) ? page_mask : '0;
endmodule

// File: rtl/fpm_seq_chk.sv
module fpm_seq_chk #(
  parameter int T_RP    = 3,
  parameter int RAS_MAX = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic req_ready,
  input logic rd_valid
);
  localparam int CW = $clog2(RAS_MAX + T_RP + 2);
  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= CW'(T_RP);
    end else begin
      lo_cnt <= dram_ras_n ? '0 : lo_cnt + 1'b1;
      if (!dram_ras_n)                hi_cnt <= '0;
      else if (int'(hi_cnt) < T_RP)   hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> int'(lo_cnt) < RAS_MAX); // R7
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> int'(hi_cnt) >= T_RP); // R6
  AST_CAS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n); // R3
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !req_ready); // R11
  AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_cas_n && !dram_oe_n) && dram_cas_n); // R10
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n)); // R9
endmodule

bind fpm_seq fpm_seq_chk #(.T_RP(T_RP), .RAS_MAX(RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .req_ready(req_ready),
  .rd_valid(rd_valid)
);

// File: tb/test_fpm_seq.sv
`timescale 1ns/100ps
module test_fpm_seq;
  localparam int RW = 3, CLW = 4, DW = 8;
  localparam int FL = 4, CL = 2, TRP = 3, RMAX = 24;
  localparam int AW = (RW > CLW) ? RW : CLW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wr = 0;
  logic req_ready, rd_valid;
  logic [RW-1:0] req_row = '0;
  logic [CLW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0, wr_mask = '1, rd_data;
  logic [AW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [DW-1:0] dram_dq_out, dram_bwe, dram_dq_in;

  always #2.5 clk = ~clk;

  fpm_seq #(.ROW_W(RW), .COL_W(CLW), .DATA_W(DW), .FIRST_LAT(FL),
            .CAS_LAT(CL), .T_RP(TRP), .RAS_MAX(RMAX)) i_fpm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_wr(req_wr),
    .req_wdata(req_wdata), .wr_mask(wr_mask), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_bwe(dram_bwe), .dram_dq_in(dram_dq_in));

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: data only valid once the access delay has elapsed
  logic [DW-1:0] mem [2**(RW+CLW)];
  logic [RW-1:0] m_row = '0;
  int m_cnt = 0;
  bit m_first = 0, m_prev_ras = 1, m_prev_cas = 1;
  assign dram_dq_in = (!dram_cas_n && !dram_oe_n &&
                       m_cnt >= (m_first ? FL : CL)) ?
                      mem[{m_row, dram_addr[CLW-1:0]}] : 8'hEE;
  always @(negedge clk) begin
    if (!dram_ras_n && m_prev_ras) begin m_row <= dram_addr[RW-1:0]; m_first <= 1; end
    if (!dram_cas_n) m_cnt <= m_cnt + 1; else m_cnt <= 0;
    if (dram_cas_n && !m_prev_cas) m_first <= 0;
    if (!dram_cas_n && !dram_we_n)
      mem[{m_row, dram_addr[CLW-1:0]}] <= (mem[{m_row, dram_addr[CLW-1:0]}] & ~dram_bwe)
                                          | (dram_dq_out & dram_bwe);
    m_prev_ras <= dram_ras_n;
    m_prev_cas <= dram_cas_n;
  end

  // reference state
  logic [DW-1:0] ref_mem [2**(RW+CLW)];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] pmask_ref = '1;
  int exp_row = 0, exp_col = 0;
  bit mask_rand = 0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] d, logic [DW-1:0] m);
    return (o & ~m) | (d & m);
  endfunction

  // monitor
  int lo_run = 0, hi_run = 100, cas_run = 0, ras_falls = 0;
  bit p_ras = 1, p_cas = 1, mon_first = 0;
  always @(negedge clk) if (rst_n) begin
    if (!dram_ras_n && p_ras) begin
      ras_falls++;
      mon_first = 1;
      check(dram_addr == AW'(exp_row), "R2 row address", dram_addr, exp_row);
      check(hi_run >= TRP, "R6 precharge", hi_run, TRP);
    end
    if (dram_ras_n && !p_ras) check(lo_run <= RMAX, "R7 ras low length", lo_run, RMAX);
    if (!dram_cas_n && p_cas) begin
      check(dram_addr[CLW-1:0] == CLW'(exp_col), "R2 column address", dram_addr, exp_col);
      check(req_ready == 0, "R11 ready low in strobe", req_ready, 0);
    end
    if (dram_cas_n && !p_cas) begin
      if (mon_first) check(cas_run == FL, "R4 first strobe length", cas_run, FL);
      else           check(cas_run == CL, "R5 page strobe length", cas_run, CL);
      mon_first = 0;
    end
    if (!dram_cas_n && !dram_we_n)
      check(dram_bwe == pmask_ref, "R9 page write mask", dram_bwe, pmask_ref);
    if (!(!dram_cas_n && !dram_we_n))
      if (dram_bwe != '0) check(0, "R9 mask outside write", dram_bwe, 0);
    if (rd_valid) begin
      if (exp_q.size() == 0) check(0, "R10 unexpected read", rd_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R10 read data", rd_data, e);
      end
    end
    lo_run  = dram_ras_n ? 0 : lo_run + 1;
    hi_run  = dram_ras_n ? hi_run + 1 : 0;
    cas_run = dram_cas_n ? 0 : cas_run + 1;
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end

  always @(negedge clk) if (mask_rand) wr_mask <= DW'($urandom);

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // call at a negedge; returns at the negedge after acceptance, valid still high
  task automatic send(input int r, input int c, input bit w, input logic [DW-1:0] d);
    int a;
    req_row = RW'(r); req_col = CLW'(c); req_wr = w; req_wdata = d; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (dram_ras_n) pmask_ref = wr_mask;
    exp_row = r; exp_col = c;
    a = r * (2**CLW) + c;
    if (w) ref_mem[a] = merge(ref_mem[a], d, pmask_ref);
    else   exp_q.push_back(ref_mem[a]);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int f0;
    bit saw;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 2**(RW+CLW); i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!rd_valid && req_ready, "R1 rd_valid low, ready high", {rd_valid, req_ready}, 2'b01);

    // fill row 1 with full mask, then read it back in one page (R3)
    wr_mask = '1;
    for (int c = 0; c < 4; c++) send(1, c, 1, DW'(8'h10 + c));
    idle(8);
    f0 = ras_falls;
    for (int c = 0; c < 3; c++) send(1, c, 0, '0);
    idle(12);
    check(ras_falls - f0 == 1, "R3 single opening for same-row burst", ras_falls - f0, 1);

    // R8: single read then nothing pending
    send(1, 3, 0, '0);
    idle(0);
    saw = 0;
    for (int k = 0; k < 20 && !saw; k++) begin
      @(negedge clk);
      if (rd_valid) begin
        saw = 1;
        @(negedge clk);
        check(dram_ras_n == 1, "R8 close when idle", dram_ras_n, 1);
      end
    end
    check(saw, "R10 single read returned", saw, 1);
    idle(6);

    // R9: mask changes after the page opens
    wr_mask = 8'h0F;
    send(2, 0, 1, 8'hFF);
    wr_mask = 8'hF0;
    send(2, 1, 1, 8'hFF);
    send(2, 0, 0, '0);
    send(2, 1, 0, '0);
    idle(12);
    check(ref_mem[2*16+1] == 8'h0F, "R9 ref mask from row opening", ref_mem[2*16+1], 8'h0F);

    // R7: long same-row burst exceeds the budget
    f0 = ras_falls;
    for (int c = 0; c < 12; c++) send(1, c % 4, 0, '0);
    idle(12);
    check(ras_falls - f0 >= 2, "R7 burst split across openings", ras_falls - f0, 2);

    // random phase
    mask_rand = 1;
    for (int n = 0; n < 400; n++) begin
      send($urandom_range(0, 2), $urandom_range(0, 15), $urandom_range(0, 1), DW'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 5));
    end
    idle(20);
    mask_rand = 0;
    // read everything back
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 16; c++) send(r, c, 0, '0);
    idle(20);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule